// File: doc/BRIEF.md
# PLL Mode and Bandwidth Controller

This block supervises a bank of independent digitally controlled PLL channels. For each channel it follows the operating mode through four states: free-run, acquisition, locked and holdover. It also chooses which of two register-held loop-bandwidth codes drives that channel's loop filter. The phase detector, loop filter, oscillator and lock-measurement logic are outside the block. Input validity and the raw lock indication arrive as flags that are already synchronous to the block clock.

Acquisition can be slow when the normal bandwidth is very narrow. Each channel therefore has a fastlock enable. While the channel acquires with this enable set, a wider temporary code is presented. The controller switches back to the narrow code by itself in the cycle lock is declared, with no software action. A lock indication only counts once it has held for a programmable number of consecutive cycles. A per-channel soft reset returns that one channel to free-run and leaves the other channels alone.

The states are FREE (2'b00), ACQ (2'b01), LOCK (2'b10) and HOLD (2'b11). The transitions are:
- FREE->ACQ when the input becomes valid.
- ACQ->LOCK when lock is qualified.
- ACQ->FREE when the input is lost.
- LOCK->HOLD when the input is lost.
- LOCK->ACQ when the lock flag drops while the input is still valid.
- HOLD->ACQ when the input returns.
- Any state->FREE on a soft reset.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After rst_n is released, every channel reports mode 2'b00 (free-run) and its active bandwidth equals its normal code.
- R2: A channel in free-run moves to acquisition (2'b01) one cycle after in_valid is sampled high. It stays in free-run while in_valid is low.
- R3: A channel in acquisition enters locked (2'b10) at the clock edge where lock_flag has been sampled high on lock_qual_len consecutive edges, all within acquisition. A qualify length of 0 behaves as 1. A single low sample restarts the count.
- R4: Loss of in_valid in acquisition returns the channel to free-run. This takes priority over lock qualification completing on the same edge.
- R5: In locked, loss of in_valid moves the channel to holdover (2'b11). A low lock_flag while in_valid is still high moves it back to acquisition.
- R6: In holdover, the channel stays in holdover while in_valid is low, whatever lock_flag does. A returning in_valid moves it to acquisition, never straight to locked.
- R7: With fast_en high, bw_act carries the fastlock code exactly while the mode is acquisition. In every other mode it carries the normal code, so the switch back happens in the same cycle the mode becomes locked.
- R8: With fast_en low, bw_act carries the normal code in every mode.
- R9: A high soft_rst for a channel forces it to free-run on the next edge and clears its lock qualification count. It overrides any other transition on that edge and does not disturb other channels.
- R10: Channels share only the clock, rst_n and lock_qual_len. Stimulus on one channel never changes the mode or bandwidth of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset for all channels |
| soft_rst | input | NCH | Per-channel synchronous reset to free-run |
| in_valid | input | NCH | Per-channel input-clock valid flag |
| lock_flag | input | NCH | Per-channel raw lock-detect flag |
| fast_en | input | NCH | Per-channel fastlock enable |
| lock_qual_len | input | CNT_W | Consecutive lock samples needed to declare lock (0 treated as 1) |
| bw_norm | input | NCH*BW_W | Normal bandwidth codes, channel c at bits [c*BW_W +: BW_W] |
| bw_fast | input | NCH*BW_W | Fastlock bandwidth codes, same packing |
| mode | output | NCH*2 | Per-channel mode, channel c at bits [c*2 +: 2] |
| bw_act | output | NCH*BW_W | Per-channel active bandwidth code |

## Verification
Completion of lock qualification can fall on the same edge as either a soft reset or a loss of input validity. Both events want to move the channel somewhere different. The bench holds lock_flag high until only the final qualifying sample remains, then raises soft_rst, or drops in_valid, for exactly that edge. It judges the outcome by requiring free-run with the normal code on the following cycle, not locked. A further case restarts qualification after a soft reset taken mid-count, which shows that the partial count was discarded.

// File: rtl/pllmc_pkg.sv
package pllmc_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_ACQ  = 2'b01,
        MODE_LOCK = 2'b10,
        MODE_HOLD = 2'b11
    } pll_mode_e;
endpackage

// File: rtl/pllmc_lock_qual.sv
module pllmc_lock_qual #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lock_flag,
    input  logic [CNT_W-1:0] qual_len,
    output logic             qualified
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W:0]   need;
    logic [CNT_W:0]   seen;

    // Number of consecutive high samples needed, zero promoted to one
    always_comb begin
        need = (qual_len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, qual_len};
        seen = {1'b0, run_cnt} + {{CNT_W{1'b0}}, 1'b1};
        qualified = lock_flag && (seen >= need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr || !lock_flag) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pllmc_mode_fsm.sv
module pllmc_mode_fsm
    import pllmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_rst,
    input  logic      in_valid,
    input  logic      lock_flag,
    input  logic      lock_ok,
    output pll_mode_e state_q
);
    pll_mode_e state_d;

    // Next state: soft reset first, then loss of input, then lock events
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = MODE_FREE;
        end else begin
            unique case (state_q)
                MODE_FREE: begin
                    if (in_valid) state_d = MODE_ACQ;
                end
                MODE_ACQ: begin
                    if (!in_valid)    state_d = MODE_FREE;
                    else if (lock_ok) state_d = MODE_LOCK;
                end
                MODE_LOCK: begin
                    if (!in_valid)      state_d = MODE_HOLD;
                    else if (!lock_flag) state_d = MODE_ACQ;
                end
                MODE_HOLD: begin
                    if (in_valid) state_d = MODE_ACQ;
                end
                default: state_d = MODE_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_FREE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/pllmc_bw_sel.sv
module pllmc_bw_sel
    import pllmc_pkg::*;
#(
    parameter int BW_W = 8
) (
    input  pll_mode_e        mode_i,
    input  logic             fast_en,
    input  logic [BW_W-1:0]  code_norm,
    input  logic [BW_W-1:0]  code_fast,
    output logic [BW_W-1:0]  code_act
);
    always_comb begin
        unique case (mode_i)
            MODE_ACQ: code_act = fast_en ? code_fast : code_norm;
            MODE_FREE,
            MODE_LOCK,
            MODE_HOLD: code_act = code_norm;
            default:   code_act = code_norm;
        endcase
    end
endmodule

// File: rtl/pllmc_channel.sv
module pllmc_channel
    import pllmc_pkg::*;
#(
    parameter int BW_W  = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             in_valid,
    input  logic             lock_flag,
    input  logic             fast_en,
    input  logic [CNT_W-1:0] qual_len,
    input  logic [BW_W-1:0]  code_norm,
    input  logic [BW_W-1:0]  code_fast,
    output logic [1:0]       mode_o,
    output logic [BW_W-1:0]  code_act
);
    pll_mode_e cur_mode;
    logic      lock_ok;
    logic      qual_clr;

    assign qual_clr = soft_rst || (cur_mode != MODE_ACQ);

    pllmc_lock_qual #(.CNT_W(CNT_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (qual_clr),
        .lock_flag (lock_flag),
        .qual_len  (qual_len),
        .qualified (lock_ok)
    );

    pllmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .in_valid  (in_valid),
        .lock_flag (lock_flag),
        .lock_ok   (lock_ok),
        .state_q   (cur_mode)
    );

    pllmc_bw_sel #(.BW_W(BW_W)) u_bw (
        .mode_i    (cur_mode),
        .fast_en   (fast_en),
        .code_norm (code_norm),
        .code_fast (code_fast),
        .code_act  (code_act)
    );

    assign mode_o = cur_mode;
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl #(
    parameter int NCH   = 2,
    parameter int BW_W  = 8,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    soft_rst,
    input  logic [NCH-1:0]    in_valid,
    input  logic [NCH-1:0]    lock_flag,
    input  logic [NCH-1:0]    fast_en,
    input  logic [CNT_W-1:0]  lock_qual_len,
    input  logic [NCH*BW_W-1:0] bw_norm,
    input  logic [NCH*BW_W-1:0] bw_fast,
    output logic [NCH*2-1:0]  mode,
    output logic [NCH*BW_W-1:0] bw_act
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pllmc_channel #(.BW_W(BW_W), .CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst[c]),
            .in_valid  (in_valid[c]),
            .lock_flag (lock_flag[c]),
            .fast_en   (fast_en[c]),
            .qual_len  (lock_qual_len),
            .code_norm (bw_norm[c*BW_W +: BW_W]),
            .code_fast (bw_fast[c*BW_W +: BW_W]),
            .mode_o    (mode[c*2 +: 2]),
            .code_act  (bw_act[c*BW_W +: BW_W])
        );
    end
endmodule

// File: rtl/pllmc_chk.sv
module pllmc_chk #(
    parameter int NCH   = 2,
    parameter int BW_W  = 8,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    soft_rst,
    input logic [NCH-1:0]    in_valid,
    input logic [NCH-1:0]    lock_flag,
    input logic [NCH-1:0]    fast_en,
    input logic [CNT_W-1:0]  lock_qual_len,
    input logic [NCH*BW_W-1:0] bw_norm,
    input logic [NCH*BW_W-1:0] bw_fast,
    input logic [NCH*2-1:0]  mode,
    input logic [NCH*BW_W-1:0] bw_act
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [1:0]      m;
        logic [BW_W-1:0] act, nrm;
        assign m   = mode[c*2 +: 2];
        assign act = bw_act[c*BW_W +: BW_W];
        assign nrm = bw_norm[c*BW_W +: BW_W];

        p_soft_to_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst[c] |=> (m == 2'b00));

        p_free_to_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b00 && in_valid[c] && !soft_rst[c]) |=> (m == 2'b01));

        p_lock_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b10 && $past(m) == 2'b01) |-> $past(lock_flag[c]));

        p_acq_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b01 && !in_valid[c]) |=> (m == 2'b00));

        p_lock_to_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b10 && !in_valid[c] && !soft_rst[c]) |=> (m == 2'b11));

        p_hold_no_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 2'b11) |=> (m != 2'b10));

        p_norm_outside_acq_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (m != 2'b01) |-> (act == nrm));

        p_fast_off_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !fast_en[c] |-> (act == nrm));
    end
endmodule

bind pll_mode_ctrl pllmc_chk #(.NCH(NCH), .BW_W(BW_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .in_valid      (in_valid),
    .lock_flag     (lock_flag),
    .fast_en       (fast_en),
    .lock_qual_len (lock_qual_len),
    .bw_norm       (bw_norm),
    .bw_fast       (bw_fast),
    .mode          (mode),
    .bw_act        (bw_act)
);

// File: tb/tb_pll_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pll_mode_ctrl;
    localparam int NCH = 2;
    localparam int BW_W = 8;
    localparam int CNT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    soft_rst = '0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH-1:0]    lock_flag = '0;
    logic [NCH-1:0]    fast_en = '1;
    logic [CNT_W-1:0]  lock_qual_len = 4'd4;
    logic [NCH*BW_W-1:0] bw_norm = {8'h34, 8'h12};
    logic [NCH*BW_W-1:0] bw_fast = {8'hE7, 8'hC5};
    logic [NCH*2-1:0]  mode;
    logic [NCH*BW_W-1:0] bw_act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_mode_ctrl #(.NCH(NCH), .BW_W(BW_W), .CNT_W(CNT_W)) dut (.*);

    localparam logic [1:0] FREE = 2'b00, ACQ = 2'b01, LOCK = 2'b10, HOLD = 2'b11;

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_mode(int ch, logic [1:0] exp, string req);
        logic [1:0] act = mode[ch*2 +: 2];
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d mode actual=%b expected=%b", req, ch, act, exp);
        end
    endtask

    task automatic chk_bw(int ch, bit want_fast, string req);
        logic [BW_W-1:0] exp = want_fast ? bw_fast[ch*BW_W +: BW_W] : bw_norm[ch*BW_W +: BW_W];
        logic [BW_W-1:0] act = bw_act[ch*BW_W +: BW_W];
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d bw actual=%h expected=%h", req, ch, act, exp);
        end
    endtask

    task automatic ch_clean(int ch);
        soft_rst[ch] = 1'b1;
        in_valid[ch] = 1'b0;
        lock_flag[ch] = 1'b0;
        step();
        soft_rst[ch] = 1'b0;
        step();
    endtask

    task automatic t_reset();
        chk_mode(0, FREE, "R1"); chk_mode(1, FREE, "R1");
        chk_bw(0, 0, "R1");      chk_bw(1, 0, "R1");
    endtask

    task automatic t_free_to_acq();
        ch_clean(0);
        step(2);
        chk_mode(0, FREE, "R2 stays free");
        in_valid[0] = 1'b1;
        step();
        chk_mode(0, ACQ, "R2");
        chk_bw(0, 1, "R7 fast in acq");
        chk_mode(1, FREE, "R10");
    endtask

    task automatic t_qualify();
        ch_clean(0);
        lock_qual_len = 4'd4;
        in_valid[0] = 1'b1;
        step();
        lock_flag[0] = 1'b1; step(2);
        lock_flag[0] = 1'b0; step();
        lock_flag[0] = 1'b1; step(3);
        chk_mode(0, ACQ, "R3 count restarted");
        step();
        chk_mode(0, LOCK, "R3");
        chk_bw(0, 0, "R7 revert on lock");
        lock_flag[0] = 1'b0; step();
        chk_mode(0, ACQ, "R5 lock drop");
        in_valid[0] = 1'b0; step();
        chk_mode(0, FREE, "R4 loss in acq");
    endtask

    task automatic t_holdover();
        ch_clean(0);
        lock_qual_len = 4'd1;
        in_valid[0] = 1'b1; step();
        lock_flag[0] = 1'b1; step();
        chk_mode(0, LOCK, "R3 len1");
        in_valid[0] = 1'b0; step();
        chk_mode(0, HOLD, "R5 holdover");
        chk_bw(0, 0, "R7 hold norm");
        step(2);
        chk_mode(0, HOLD, "R6 stays hold");
        in_valid[0] = 1'b1; step();
        chk_mode(0, ACQ, "R6 return to acq");
        chk_bw(0, 1, "R7 fast again");
        ch_clean(0);
        lock_qual_len = 4'd0;
        in_valid[0] = 1'b1; step();
        lock_flag[0] = 1'b1; step();
        chk_mode(0, LOCK, "R3 len0 as 1");
    endtask

    task automatic t_fast_off();
        ch_clean(1);
        lock_qual_len = 4'd2;
        fast_en[1] = 1'b0;
        in_valid[1] = 1'b1; step();
        chk_mode(1, ACQ, "R8 acq");
        chk_bw(1, 0, "R8 acq norm");
        lock_flag[1] = 1'b1; step(2);
        chk_mode(1, LOCK, "R8 lock");
        chk_bw(1, 0, "R8 lock norm");
        in_valid[1] = 1'b0; step();
        chk_bw(1, 0, "R8 hold norm");
        fast_en[1] = 1'b1;
    endtask

    task automatic t_soft_reset();
        ch_clean(0); ch_clean(1);
        lock_qual_len = 4'd4;
        in_valid[1] = 1'b1;
        in_valid[0] = 1'b1; step();
        lock_flag[0] = 1'b1; step(2);
        soft_rst[0] = 1'b1; step();
        chk_mode(0, FREE, "R9");
        chk_bw(0, 0, "R9 norm");
        chk_mode(1, ACQ, "R9 other channel");
        chk_bw(1, 1, "R10 other bw");
        soft_rst[0] = 1'b0; step();
        chk_mode(0, ACQ, "R9 reenter");
        step(3);
        chk_mode(0, ACQ, "R9 count cleared");
        step();
        chk_mode(0, LOCK, "R9 relock");
    endtask

    task automatic t_concurrent();
        ch_clean(0);
        lock_qual_len = 4'd2;
        in_valid[0] = 1'b1; step();
        lock_flag[0] = 1'b1; step();
        soft_rst[0] = 1'b1; step();
        chk_mode(0, FREE, "R9 over qualify");
        soft_rst[0] = 1'b0;
        ch_clean(0);
        in_valid[0] = 1'b1; step();
        lock_flag[0] = 1'b1; step();
        in_valid[0] = 1'b0; step();
        chk_mode(0, FREE, "R4 over qualify");
        chk_bw(0, 0, "R4 norm");
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_free_to_acq();
        t_qualify();
        t_holdover();
        t_fast_off();
        t_soft_reset();
        t_concurrent();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule